// File: doc/BRIEF.md
# Output Macrocell with Selectable Registered, Combinational and Input Modes

This block is one output cell of a programmable sum-of-products device. It gathers a set of product terms coming from the AND plane, ORs them into a single sum, and offers that sum to the pin either straight through or after capture in a D flip-flop. A polarity bit can invert the value on its way to the pin. The cell controls a tri-state enable for the pin. It also returns one selected signal to the input matrix, so that other cells can use it as an input.

A two-bit mode field sets the cell's role. The four roles are: a registered output, a combinational output that feeds back its own complemented value, a combinational output that feeds back the pin, and a pure input with the driver switched off. The flip-flop samples the sum on every rising clock edge in every mode. A synchronous reset clears the flip-flop, and this clear acts on the flop value before the polarity stage.

Top module: `pin_macrocell`

## Requirements
- R1: In the combinational modes (mode 2'b01 and 2'b11) with pol_inv=0, pin_out equals the OR of all pterm bits in the same cycle, whichever bit is set.
- R2: pol_inv=1 inverts the value on pin_out in both the registered mode and the combinational modes.
- R3: In registered mode (mode 2'b00), pin_out equals the flop value XOR pol_inv. The flop takes the OR of pterm at each rising clk edge, and pterm changes between edges do not reach pin_out.
- R4: In registered mode, pin_oe is 1 whatever the value of oe_term.
- R5: In registered mode, fb is the complement of the flop value, and pin_in has no effect on fb.
- R6: In both combinational modes, pin_oe follows oe_term in the same cycle.
- R7: In mode 2'b01, fb is the complement of pin_out, and pin_in has no effect on fb.
- R8: In mode 2'b11, fb equals pin_in.
- R9: In input mode (mode 2'b10), pin_oe is 0, pin_out is 0 and fb equals pin_in, whatever pterm and oe_term are.
- R10: When rst is high at a rising clk edge, the flop is cleared to 0 even if pterm is non-zero. After that edge in registered mode, pin_out equals pol_inv and fb is 1.
- R11: A mode change alters the combinational outputs at once. The flop samples the sum in every mode, so on a switch into registered mode the pin shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flop |
| rst | input | 1 | Synchronous clear of the flip-flop |
| pterm | input | NUM_TERMS | Product terms from the AND plane |
| oe_term | input | 1 | Product term used as pin enable in the combinational modes |
| mode | input | 2 | 00 registered, 01 combinational with own feedback, 10 input only, 11 combinational with pin feedback |
| pol_inv | input | 1 | 1 inverts the value driven to the pin |
| pin_in | input | 1 | Value read back from the pin |
| pin_out | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Tri-state enable for the pin driver |
| fb | output | 1 | Feedback signal returned to the input matrix |

## Verification
Two functions can act on the same clock edge: the synchronous clear and the capture of a non-zero sum. The bench raises rst while every product term is high, then reads pin_out and fb after that edge, and expects the clear to win. A mode switch can also coincide with a fresh capture. The bench moves from a combinational mode into registered mode between edges. It expects the pin to show the value stored at the earlier edge at once, and then the newly sampled sum after the next edge.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    typedef enum logic [1:0] {
        MC_REG      = 2'b00,
        MC_COMB_FB  = 2'b01,
        MC_INPUT    = 2'b10,
        MC_COMB_PIN = 2'b11
    } mc_mode_e;

    typedef struct packed {
        logic q;
    } mc_state_t;

endpackage

// File: rtl/mc_sum_or.sv
`timescale 1ns/1ps
module mc_sum_or #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    output logic                 sum
);
    localparam int CHAIN_LEN = NUM_TERMS + 1;

    logic [CHAIN_LEN-1:0] acc;

    assign acc[0] = 1'b0;

    // Each stage ORs in one more term; the last tap is the sum.
    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_or_stage
        assign acc[g+1] = acc[g] | terms[g];
    end

    assign sum = acc[CHAIN_LEN-1];
endmodule

// File: rtl/mc_polarity.sv
`timescale 1ns/1ps
module mc_polarity (
    input  logic raw,
    input  logic inv,
    output logic y
);
    assign y = raw ^ inv;
endmodule

// File: rtl/mc_out_ctrl.sv
`timescale 1ns/1ps
module mc_out_ctrl
    import mc_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     comb_y,
    input  logic     reg_y,
    input  logic     oe_term,
    output logic     drive,
    output logic     oe
);
    always_comb begin
        drive = 1'b0;
        oe    = 1'b0;
        unique case (mode)
            MC_REG: begin
                drive = reg_y;
                oe    = 1'b1;
            end
            MC_COMB_FB, MC_COMB_PIN: begin
                drive = comb_y;
                oe    = oe_term;
            end
            MC_INPUT: begin
                drive = 1'b0;
                oe    = 1'b0;
            end
            default: begin
                drive = 1'b0;
                oe    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mc_fb_sel.sv
`timescale 1ns/1ps
module mc_fb_sel
    import mc_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     flop_q,
    input  logic     comb_y,
    input  logic     pin_in,
    output logic     fb
);
    always_comb begin
        fb = 1'b0;
        unique case (mode)
            MC_REG:      fb = ~flop_q;
            MC_COMB_FB:  fb = ~comb_y;
            MC_COMB_PIN: fb = pin_in;
            MC_INPUT:    fb = pin_in;
            default:     fb = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_macrocell.sv
`timescale 1ns/1ps
module pin_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 oe_term,
    input  logic [1:0]           mode,
    input  logic                 pol_inv,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb
);
    mc_mode_e  mode_sel;
    mc_state_t st_d;
    mc_state_t st_q;
    logic      sum;
    logic      comb_y;
    logic      reg_y;

    assign mode_sel = mc_mode_e'(mode);

    mc_sum_or #(.NUM_TERMS(NUM_TERMS)) u_or (
        .terms (pterm),
        .sum   (sum)
    );

    // Next-state: the flop samples the sum in every mode; the clear wins.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.q = 1'b0;
        end else begin
            st_d.q = sum;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    mc_polarity u_pol_comb (
        .raw (sum),
        .inv (pol_inv),
        .y   (comb_y)
    );

    mc_polarity u_pol_reg (
        .raw (st_q.q),
        .inv (pol_inv),
        .y   (reg_y)
    );

    mc_out_ctrl u_out (
        .mode    (mode_sel),
        .comb_y  (comb_y),
        .reg_y   (reg_y),
        .oe_term (oe_term),
        .drive   (pin_out),
        .oe      (pin_oe)
    );

    mc_fb_sel u_fb (
        .mode   (mode_sel),
        .flop_q (st_q.q),
        .comb_y (comb_y),
        .pin_in (pin_in),
        .fb     (fb)
    );
endmodule

// File: rtl/mc_checks.sv
`timescale 1ns/1ps
module mc_checks #(
    parameter int NUM_TERMS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_TERMS-1:0] pterm,
    input logic                 oe_term,
    input logic [1:0]           mode,
    input logic                 pol_inv,
    input logic                 pin_in,
    input logic                 pin_out,
    input logic                 pin_oe,
    input logic                 fb
);
    // R4: registered cells always drive
    a_r4_reg_oe: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> pin_oe);

    // R9: input-only cells never drive and return the pin
    a_r9_input_off: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |-> (!pin_oe && !pin_out && fb == pin_in));

    // R6: combinational enable follows the enable term
    a_r6_comb_oe: assert property (@(posedge clk) disable iff (rst)
        (mode[0] == 1'b1) |-> (pin_oe == oe_term));

    // R7: own feedback is the complement of the pin value
    a_r7_fb_comp: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |-> (fb == !pin_out));

    // R8: pin feedback mode
    a_r8_fb_pin: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |-> (fb == pin_in));

    // R3 / R5: registered feedback reflects the sum sampled at the last edge
    a_r5_reg_fb: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !$past(rst)) |-> (fb == !(|$past(pterm))));

    // R10: after a clear edge the registered feedback is high
    a_r10_clear: assert property (@(posedge clk)
        ($past(rst) && mode == 2'b00) |-> (fb && pin_out == pol_inv));
endmodule

bind pin_macrocell mc_checks #(.NUM_TERMS(NUM_TERMS)) u_mc_checks (
    .clk     (clk),
    .rst     (rst),
    .pterm   (pterm),
    .oe_term (oe_term),
    .mode    (mode),
    .pol_inv (pol_inv),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb)
);

// File: tb/pin_macrocell_test.sv
`timescale 1ns/1ps
module pin_macrocell_test;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] pterm = '0;
    logic          oe_term = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          pol_inv = 1'b0;
    logic          pin_in = 1'b0;
    logic          pin_out;
    logic          pin_oe;
    logic          fb;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pin_macrocell #(.NUM_TERMS(NT)) uut (
        .clk(clk), .rst(rst), .pterm(pterm), .oe_term(oe_term),
        .mode(mode), .pol_inv(pol_inv), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // drive between edges, then let combinational paths settle
    task automatic settle();
        #2;
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; mode = 2'b00; pol_inv = 1'b0; pterm = '1; oe_term = 1'b0;
        edge_then_settle();
        chk("R10", "pin_out after clear", pin_out, 1'b0);
        chk("R10", "fb after clear", fb, 1'b1);
        chk("R4", "oe in reg mode", pin_oe, 1'b1);
        pol_inv = 1'b1;
        settle();
        chk("R10", "pin_out cleared, inverted", pin_out, 1'b1);
        @(negedge clk);
        rst = 1'b0; pol_inv = 1'b0; pterm = '0;
        edge_then_settle();
    endtask

    task automatic t_comb_or();
        @(negedge clk);
        mode = 2'b01; pol_inv = 1'b0; oe_term = 1'b1;
        pterm = '0; settle();
        chk("R1", "no term set", pin_out, 1'b0);
        pterm = 8'h80; settle();
        chk("R1", "top term set", pin_out, 1'b1);
        pterm = 8'h01; settle();
        chk("R1", "bottom term set", pin_out, 1'b1);
        pterm = 8'h24; settle();
        chk("R1", "two terms set", pin_out, 1'b1);
        pol_inv = 1'b1; settle();
        chk("R2", "comb inverted", pin_out, 1'b0);
        pterm = '0; settle();
        chk("R2", "comb inverted zero", pin_out, 1'b1);
        pol_inv = 1'b0;
    endtask

    task automatic t_comb_fb();
        @(negedge clk);
        mode = 2'b01; pterm = 8'h10; pin_in = 1'b1; settle();
        chk("R7", "fb complement of pin", fb, 1'b0);
        pin_in = 1'b0; settle();
        chk("R7", "pin_in ignored", fb, 1'b0);
        pterm = '0; pin_in = 1'b1; settle();
        chk("R7", "fb complement of zero", fb, 1'b1);
        oe_term = 1'b0; settle();
        chk("R6", "oe low follows term", pin_oe, 1'b0);
        oe_term = 1'b1; settle();
        chk("R6", "oe high follows term", pin_oe, 1'b1);
    endtask

    task automatic t_comb_pin();
        @(negedge clk);
        mode = 2'b11; pterm = 8'h02; pol_inv = 1'b0; oe_term = 1'b0;
        pin_in = 1'b1; settle();
        chk("R8", "fb follows pin high", fb, 1'b1);
        pin_in = 1'b0; settle();
        chk("R8", "fb follows pin low", fb, 1'b0);
        chk("R1", "pin mode still drives sum", pin_out, 1'b1);
        chk("R6", "pin mode oe from term", pin_oe, 1'b0);
    endtask

    task automatic t_input();
        @(negedge clk);
        mode = 2'b10; pterm = '1; oe_term = 1'b1; pol_inv = 1'b1;
        pin_in = 1'b1; settle();
        chk("R9", "driver off", pin_oe, 1'b0);
        chk("R9", "pin_out low", pin_out, 1'b0);
        chk("R9", "fb is pin high", fb, 1'b1);
        pin_in = 1'b0; settle();
        chk("R9", "fb is pin low", fb, 1'b0);
        pol_inv = 1'b0;
    endtask

    task automatic t_registered();
        @(negedge clk);
        mode = 2'b00; pol_inv = 1'b0; pterm = '0; oe_term = 1'b0;
        edge_then_settle();
        @(negedge clk);
        pterm = 8'h08; settle();
        chk("R3", "held before edge", pin_out, 1'b0);
        chk("R4", "oe ignores term", pin_oe, 1'b1);
        edge_then_settle();
        chk("R3", "captured at edge", pin_out, 1'b1);
        chk("R5", "fb is flop complement", fb, 1'b0);
        @(negedge clk);
        pterm = '0; pin_in = 1'b1; settle();
        chk("R3", "mid-cycle change blocked", pin_out, 1'b1);
        chk("R5", "pin_in ignored", fb, 1'b0);
        pol_inv = 1'b1; settle();
        chk("R2", "reg inverted", pin_out, 1'b0);
        edge_then_settle();
        chk("R3", "zero captured, inverted", pin_out, 1'b1);
        chk("R5", "fb after zero", fb, 1'b1);
        pol_inv = 1'b0; pin_in = 1'b0;
    endtask

    task automatic t_mode_switch();
        @(negedge clk);
        mode = 2'b01; pterm = 8'h40; pol_inv = 1'b0; oe_term = 1'b0;
        edge_then_settle();
        @(negedge clk);
        pterm = '0; settle();
        chk("R11", "comb sees new sum at once", pin_out, 1'b0);
        mode = 2'b00; settle();
        chk("R11", "reg shows stored value", pin_out, 1'b1);
        chk("R11", "reg oe at once", pin_oe, 1'b1);
        edge_then_settle();
        chk("R11", "reg takes new sum at edge", pin_out, 1'b0);
    endtask

    task automatic t_clear_collision();
        @(negedge clk);
        mode = 2'b00; pterm = '1; rst = 1'b0;
        edge_then_settle();
        chk("R3", "flop set before clear", pin_out, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        edge_then_settle();
        chk("R10", "clear beats capture", pin_out, 1'b0);
        chk("R10", "fb high after clear", fb, 1'b1);
        @(negedge clk);
        rst = 1'b0; pterm = '0;
        edge_then_settle();
    endtask

    initial begin
        t_reset();
        t_comb_or();
        t_comb_fb();
        t_comb_pin();
        t_input();
        t_registered();
        t_mode_switch();
        t_clear_collision();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule